// File: doc/BRIEF.md
# Tracking potentiometer scan controller

The block reads 24 analog front-panel controls. It does this without running a full conversion on each control. Instead it follows each control one step at a time. For every control, the block does three things:

- It drives an 8-bit select code to three external 8-input analog multiplexers.
- It puts the value last stored for that control on an external DAC.
- After a programmable settling time, it samples two window-comparator flags. One flag says the control voltage is above the DAC level, the other says it is below.

The block holds a 24-entry value table and a small pending-direction state for each control. A stored value moves by one count only when two consecutive scans report movement in the same direction. This filters jitter and drift around a resting position.

A pulse on `start` begins one scan over all controls. When the last control has been sampled, the block inhibits every multiplexer and raises `scan_done` for one cycle. Each accepted move produces a one-cycle change strobe with the control index and the new value. The whole table can be read at any time through a combinational read port.

Top module: `pot_scan_ctrl`

## Requirements
- R1: After reset, `mux_sel` is 38h, `busy` and `chg_stb` are 0, and every table entry reads 00h. Whenever `busy` is 0, `mux_sel` is 38h.
- R2: A scan visits controls 0 to 23 in order, with select code 18h+i for i<8, 28h+(i-8) for 8≤i<16, and 30h+(i-16) for i≥16. Bits 7:6 are 0, exactly one of bits 5:3 is low (the active-low inhibit of the enabled multiplexer), and bits 2:0 pick the channel.
- R3: In the cycle after the last control is sampled, `mux_sel` is 38h, `scan_done` is high for exactly that one cycle, and in the cycle after it `busy` is 0.
- R4: Each control is selected for `settle_len`+1 cycles. The comparator flags are sampled only at the clock edge that ends the last of those cycles. Flag values in earlier cycles have no effect.
- R5: While a control is selected, `dac_val` equals that control's stored value.
- R6: A sample with neither flag set, or with both flags set, counts as no movement. It leaves the value unchanged and clears the pending direction.
- R7: A sample of `cmp_above` alone (up) or `cmp_below` alone (down) that matches the pending direction commits a step of +1 or -1 and clears the pending direction.
- R8: A single step followed by no movement or by a reversal is discarded. A reversal becomes the new pending direction, so the value moves only after one more sample in that new direction.
- R9: Values saturate at 00h and FFh. A commit at a limit leaves the value unchanged, clears the pending direction and raises no strobe.
- R10: `chg_stb` is high for one cycle, in the cycle after the sampling edge, for each commit that changes a value. In that cycle `chg_idx` and `chg_val` carry the control and its new value. `chg_stb` is low at all other times.
- R11: Only a `start` seen while `busy` is 0 begins a scan. A `start` during a scan, including its `scan_done` cycle, is ignored.
- R12: `rd_val` shows the stored value at `rd_idx` in the same cycle, and 00h for indices 24 to 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one scan when idle |
| settle_len | input | CNT_W (8) | Extra settling cycles per control |
| cmp_above | input | 1 | Control voltage is above the DAC level |
| cmp_below | input | 1 | Control voltage is below the DAC level |
| mux_sel | output | 8 | Multiplexer inhibit and channel code |
| dac_val | output | 8 | Stored value of the selected control, to the DAC |
| busy | output | 1 | A scan is in progress |
| scan_done | output | 1 | One-cycle pulse after the clear code is driven |
| chg_stb | output | 1 | A stored value changed |
| chg_idx | output | 5 | Index of the changed control |
| chg_val | output | 8 | New value of the changed control |
| rd_idx | input | 5 | Table read index |
| rd_val | output | 8 | Table read data |

## Verification
The bench runs a behavioural reference model and compares all outputs on every clock. It drives random flag noise during the settling cycles. A design that samples early, or on any cycle other than the last, then drifts away from the model.

Directed scans cover the direction filter:

- a single up step, then silence;
- up then down, then up twice;
- both flags set together.

A filter that commits after one step, or keeps a stale pending direction across a silent scan, would move a value one count early.

A long run drives one control to FFh and back to 00h. It counts strobes to catch a wrap-around at a limit, or a strobe fired at a limit. `start` pulses during a scan check that a second scan cannot begin or restart.

// File: rtl/pot_scan_pkg.sv
package pot_scan_pkg;

    localparam int NUM_MUX    = 3;
    localparam int CH_PER_MUX = 8;
    localparam int NUM_POTS   = NUM_MUX * CH_PER_MUX;
    localparam int IDX_W      = $clog2(NUM_POTS);
    localparam int VAL_W      = 8;
    localparam int SEL_W      = 8;

    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [VAL_W-1:0] val_t;
    typedef logic [SEL_W-1:0] sel_t;

    // All multiplexers inhibited.
    localparam sel_t SEL_CLEAR = 8'h38;

    typedef enum logic [1:0] {
        DIR_NONE = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DOWN = 2'd2
    } dir_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_DONE   = 2'd2
    } scan_st_t;

    typedef struct packed {
        val_t value;
        dir_t pend;
        logic commit;
    } upd_t;

    // Build the select code: the enabled multiplexer has its inhibit bit low.
    function automatic sel_t sel_code(input idx_t idx);
        logic [2:0] inh;
        inh = 3'b111;
        case (idx[4:3])
            2'd0:    inh[2] = 1'b0;
            2'd1:    inh[1] = 1'b0;
            default: inh[0] = 1'b0;
        endcase
        return {2'b00, inh, idx[2:0]};
    endfunction

    // A flag pair counts as movement only when exactly one flag is set.
    function automatic dir_t classify(input logic above, input logic below);
        if (above && !below)      return DIR_UP;
        else if (below && !above) return DIR_DOWN;
        else                      return DIR_NONE;
    endfunction

    // Direction-hysteresis step for one sample of one control.
    function automatic upd_t track_step(input val_t v, input dir_t pend, input dir_t d);
        upd_t u;
        u.value  = v;
        u.pend   = DIR_NONE;
        u.commit = 1'b0;
        case (d)
            DIR_UP: begin
                if (pend == DIR_UP) begin
                    if (v != '1) begin
                        u.value  = v + 1'b1;
                        u.commit = 1'b1;
                    end
                end else begin
                    u.pend = DIR_UP;
                end
            end
            DIR_DOWN: begin
                if (pend == DIR_DOWN) begin
                    if (v != '0) begin
                        u.value  = v - 1'b1;
                        u.commit = 1'b1;
                    end
                end else begin
                    u.pend = DIR_DOWN;
                end
            end
            default: u.pend = DIR_NONE;
        endcase
        return u;
    endfunction

endpackage

// File: rtl/pot_scan_seq.sv
module pot_scan_seq
    import pot_scan_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] settle_len,
    output idx_t             cur_idx,
    output logic             sample,
    output sel_t             mux_sel,
    output logic             busy,
    output logic             scan_done
);

    localparam idx_t LAST_IDX = idx_t'(NUM_POTS - 1);

    scan_st_t         st;
    logic [CNT_W-1:0] wait_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            cur_idx  <= '0;
            wait_cnt <= '0;
            mux_sel  <= SEL_CLEAR;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        st       <= ST_SETTLE;
                        cur_idx  <= '0;
                        wait_cnt <= settle_len;
                        mux_sel  <= sel_code('0);
                    end
                end
                ST_SETTLE: begin
                    if (wait_cnt == '0) begin
                        if (cur_idx == LAST_IDX) begin
                            st      <= ST_DONE;
                            cur_idx <= '0;
                            mux_sel <= SEL_CLEAR;
                        end else begin
                            cur_idx  <= cur_idx + 1'b1;
                            wait_cnt <= settle_len;
                            mux_sel  <= sel_code(cur_idx + 1'b1);
                        end
                    end else begin
                        wait_cnt <= wait_cnt - 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign sample    = (st == ST_SETTLE) && (wait_cnt == '0);
    assign busy      = (st != ST_IDLE);
    assign scan_done = (st == ST_DONE);

endmodule

// File: rtl/pot_value_table.sv
module pot_value_table
    import pot_scan_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sample,
    input  idx_t cur_idx,
    input  logic cmp_above,
    input  logic cmp_below,
    input  idx_t rd_idx,
    output val_t dac_val,
    output val_t rd_val,
    output logic chg_stb,
    output idx_t chg_idx,
    output val_t chg_val
);

    val_t vals [NUM_POTS];
    dir_t pend [NUM_POTS];
    upd_t nxt;

    always_comb begin
        nxt = track_step(vals[cur_idx], pend[cur_idx], classify(cmp_above, cmp_below));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_POTS; i++) begin
                vals[i] <= '0;
                pend[i] <= DIR_NONE;
            end
            chg_stb <= 1'b0;
            chg_idx <= '0;
            chg_val <= '0;
        end else begin
            chg_stb <= 1'b0;
            if (sample) begin
                vals[cur_idx] <= nxt.value;
                pend[cur_idx] <= nxt.pend;
                chg_stb       <= nxt.commit;
                if (nxt.commit) begin
                    chg_idx <= cur_idx;
                    chg_val <= nxt.value;
                end
            end
        end
    end

    assign dac_val = vals[cur_idx];
    assign rd_val  = (int'(rd_idx) < NUM_POTS) ? vals[rd_idx] : '0;

endmodule

// File: rtl/pot_scan_ctrl.sv
module pot_scan_ctrl
    import pot_scan_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] settle_len,
    input  logic             cmp_above,
    input  logic             cmp_below,
    output logic [7:0]       mux_sel,
    output logic [7:0]       dac_val,
    output logic             busy,
    output logic             scan_done,
    output logic             chg_stb,
    output logic [4:0]       chg_idx,
    output logic [7:0]       chg_val,
    input  logic [4:0]       rd_idx,
    output logic [7:0]       rd_val
);

    idx_t cur_idx;
    logic sample;

    pot_scan_seq #(.CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .settle_len (settle_len),
        .cur_idx    (cur_idx),
        .sample     (sample),
        .mux_sel    (mux_sel),
        .busy       (busy),
        .scan_done  (scan_done)
    );

    pot_value_table u_table (
        .clk       (clk),
        .rst       (rst),
        .sample    (sample),
        .cur_idx   (cur_idx),
        .cmp_above (cmp_above),
        .cmp_below (cmp_below),
        .rd_idx    (rd_idx),
        .dac_val   (dac_val),
        .rd_val    (rd_val),
        .chg_stb   (chg_stb),
        .chg_idx   (chg_idx),
        .chg_val   (chg_val)
    );

endmodule

// File: rtl/pot_scan_chk.sv
module pot_scan_chk (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic [7:0] mux_sel,
    input logic       busy,
    input logic       scan_done,
    input logic       chg_stb,
    input logic [4:0] chg_idx
);

    // R1
    idle_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> mux_sel == 8'h38);

    // R2
    one_mux_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && mux_sel != 8'h38) |-> (mux_sel[7:6] == 2'b00 && $countones(mux_sel[5:3]) == 2));

    // R3
    done_clear_chk: assert property (@(posedge clk) disable iff (rst)
        scan_done |-> mux_sel == 8'h38);

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        scan_done |=> (!scan_done && !busy));

    // R11
    start_only_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    // R10
    chg_range_chk: assert property (@(posedge clk) disable iff (rst)
        chg_stb |-> chg_idx < 5'd24);

endmodule

bind pot_scan_ctrl pot_scan_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .mux_sel   (mux_sel),
    .busy      (busy),
    .scan_done (scan_done),
    .chg_stb   (chg_stb),
    .chg_idx   (chg_idx)
);

// File: tb/pot_scan_ctrl_tb_top.sv
`timescale 1ns/1ps
module pot_scan_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [7:0] settle_len = 8'd0;
    logic       cmp_above = 1'b0;
    logic       cmp_below = 1'b0;
    logic [7:0] mux_sel;
    logic [7:0] dac_val;
    logic       busy;
    logic       scan_done;
    logic       chg_stb;
    logic [4:0] chg_idx;
    logic [7:0] chg_val;
    logic [4:0] rd_idx = 5'd0;
    logic [7:0] rd_val;

    always #10 clk = ~clk;

    pot_scan_ctrl dut_i (
        .clk(clk), .rst(rst), .start(start), .settle_len(settle_len),
        .cmp_above(cmp_above), .cmp_below(cmp_below),
        .mux_sel(mux_sel), .dac_val(dac_val), .busy(busy), .scan_done(scan_done),
        .chg_stb(chg_stb), .chg_idx(chg_idx), .chg_val(chg_val),
        .rd_idx(rd_idx), .rd_val(rd_val)
    );

    int total = 0;
    int fails = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model state
    int m_phase = 0;   // 0 idle, 1 scanning, 2 finished
    int m_pos = 0;
    int m_cnt = 0;
    int m_vals [24];
    int m_pend [24];   // 0 none, +1 up, -1 down
    bit m_stb = 0;
    int m_sidx = 0;
    int m_sval = 0;
    int done_cnt = 0;
    int stb10_cnt = 0;

    function automatic int exp_code(input int p);
        if (p < 8)       return 'h18 + p;
        else if (p < 16) return 'h28 + (p - 8);
        else             return 'h30 + (p - 16);
    endfunction

    function automatic int pot_of(input int code);
        if (code >= 'h18 && code <= 'h1f) return code - 'h18;
        if (code >= 'h28 && code <= 'h2f) return code - 'h28 + 8;
        if (code >= 'h30 && code <= 'h37) return code - 'h30 + 16;
        return -1;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_phase = 0; m_pos = 0; m_cnt = 0; m_stb = 0;
            for (int i = 0; i < 24; i++) begin m_vals[i] = 0; m_pend[i] = 0; end
        end else begin
            m_stb = 0;
            if (m_phase == 0) begin
                if (start) begin m_phase = 1; m_pos = 0; m_cnt = settle_len; end
            end else if (m_phase == 1) begin
                if (m_cnt == 0) begin
                    int d;
                    d = (cmp_above && !cmp_below) ? 1 : ((cmp_below && !cmp_above) ? -1 : 0);
                    if (d == 0) m_pend[m_pos] = 0;
                    else if (m_pend[m_pos] == d) begin
                        int nv;
                        m_pend[m_pos] = 0;
                        nv = m_vals[m_pos] + d;
                        if (nv >= 0 && nv <= 255) begin
                            m_vals[m_pos] = nv;
                            m_stb = 1; m_sidx = m_pos; m_sval = nv;
                        end
                    end else m_pend[m_pos] = d;
                    if (m_pos == 23) m_phase = 2;
                    else begin m_pos++; m_cnt = settle_len; end
                end else m_cnt--;
            end else begin
                m_phase = 0;
            end
        end
    end

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            int em;
            int ed;
            int er;
            em = (m_phase == 1) ? exp_code(m_pos) : 'h38;
            chk(mux_sel == em, (m_phase == 2) ? "R3 mux_sel clear" : "R2 mux_sel", mux_sel, em);
            chk(busy == (m_phase != 0), "R11 busy", busy, m_phase != 0);
            chk(scan_done == (m_phase == 2), "R3 scan_done", scan_done, m_phase == 2);
            ed = m_vals[(m_phase == 1) ? m_pos : 0];
            chk(dac_val == ed, "R5 dac_val", dac_val, ed);
            chk(chg_stb == m_stb, "R10 chg_stb", chg_stb, m_stb);
            if (m_stb) begin
                chk(chg_idx == m_sidx, "R10 chg_idx", chg_idx, m_sidx);
                chk(chg_val == m_sval, "R10 chg_val", chg_val, m_sval);
            end
            er = (rd_idx < 24) ? m_vals[rd_idx] : 0;
            chk(rd_val == er, "R12 rd_val", rd_val, er);
            if (scan_done) done_cnt++;
            if (chg_stb && chg_idx == 5'd10) stb10_cnt++;
        end
    end

    // Comparator and read-index drive, 5 ns after each rising edge
    int  fmode = 0;       // 0 random noise, 1 per-control plan
    bit  rd_hold = 0;
    logic [1:0] plan [24];   // {above, below}

    initial begin
        for (int i = 0; i < 24; i++) plan[i] = 2'b00;
        forever begin
            @(posedge clk);
            #5;
            if (fmode == 0) begin
                int r;
                r = $urandom;
                cmp_above = r[0];
                cmp_below = r[1];
            end else begin
                int p;
                p = pot_of(mux_sel);
                if (p >= 0) {cmp_above, cmp_below} = plan[p];
                else        {cmp_above, cmp_below} = 2'b00;
            end
            if (!rd_hold) rd_idx = rd_idx + 5'd1;
        end
    end

    task automatic step();
        @(posedge clk);
        #5;
    endtask

    task automatic run_scan();
        start = 1'b1;
        step();
        start = 1'b0;
        while (!scan_done) step();
        step();
    endtask

    task automatic read_chk(input int idx, input int exp, input string tag);
        rd_hold = 1;
        rd_idx = 5'(idx);
        #1;
        chk(rd_val == exp, tag, rd_val, exp);
        rd_hold = 0;
    endtask

    task automatic clear_plan();
        for (int i = 0; i < 24; i++) plan[i] = 2'b00;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        int d0;
        int v0;
        repeat (4) step();
        // R1: state held during reset
        chk(mux_sel == 8'h38, "R1 mux_sel in reset", mux_sel, 'h38);
        chk(busy == 1'b0, "R1 busy in reset", busy, 0);
        rst = 1'b0;
        step();
        chk(chg_stb == 1'b0, "R1 chg_stb after reset", chg_stb, 0);
        for (int i = 0; i < 24; i++) read_chk(i, 0, "R1 table cleared");
        read_chk(27, 0, "R12 out-of-range read");

        // Direction filter scenarios
        settle_len = 8'd2;
        fmode = 1;
        clear_plan();
        plan[3] = 2'b10; plan[4] = 2'b10; plan[7] = 2'b11; plan[8] = 2'b01; plan[9] = 2'b10;
        run_scan();
        read_chk(3, 0, "R8 single up step held");
        plan[3] = 2'b10; plan[4] = 2'b01; plan[7] = 2'b11; plan[8] = 2'b01; plan[9] = 2'b00;
        run_scan();
        read_chk(3, 1, "R7 two up steps commit");
        read_chk(4, 0, "R8 reversal discarded");
        read_chk(7, 0, "R6 both flags no move");
        read_chk(8, 0, "R9 floor saturation");
        plan[3] = 2'b00; plan[4] = 2'b10; plan[7] = 2'b00; plan[8] = 2'b00; plan[9] = 2'b10;
        run_scan();
        read_chk(4, 0, "R8 reversal only pending");
        read_chk(9, 0, "R6 silence cleared pending");
        plan[4] = 2'b10; plan[9] = 2'b10;
        run_scan();
        read_chk(4, 1, "R8 new direction commits");
        read_chk(9, 1, "R6 fresh pair commits");
        read_chk(3, 1, "R6 idle control unchanged");

        // R11: start pulses during a scan are ignored
        clear_plan();
        d0 = done_cnt;
        start = 1'b1;
        step();
        start = 1'b0;
        repeat (10) step();
        start = 1'b1;
        repeat (3) step();
        start = 1'b0;
        while (!scan_done) step();
        start = 1'b1;
        step();
        start = 1'b0;
        step();
        chk(done_cnt == d0 + 1, "R11 one scan per idle start", done_cnt, d0 + 1);
        chk(busy == 1'b0, "R11 idle after ignored start", busy, 0);

        // R4: random noise on flags during settling cycles
        fmode = 0;
        settle_len = 8'd5;
        repeat (4) run_scan();
        settle_len = 8'd0;
        repeat (4) run_scan();

        // R9: drive control 10 to the ceiling and back to the floor
        fmode = 1;
        clear_plan();
        plan[10] = 2'b10;
        v0 = m_vals[10];
        stb10_cnt = 0;
        repeat (520) run_scan();
        read_chk(10, 255, "R9 ceiling reached");
        chk(stb10_cnt == 255 - v0, "R9 strobes up to ceiling", stb10_cnt, 255 - v0);
        plan[10] = 2'b01;
        stb10_cnt = 0;
        repeat (520) run_scan();
        read_chk(10, 0, "R9 floor reached");
        chk(stb10_cnt == 255, "R9 strobes down to floor", stb10_cnt, 255);

        step();
        summary();
        $finish;
    end

endmodule